// File: doc/BRIEF.md
# Read-Capture Delay Training Sequencer

This block searches, lane by lane, for a read-capture strobe delay at which a DDR interface returns a known eight-byte pattern without error, then settles each lane in the middle of the working window. It owns a 5-bit delay setting per byte lane. Before every training read it resets the PHY read FIFO and clears the sticky read-status flags. It then fetches one byte through a valid/ready read port and compares the returned byte, together with two status flags, against the expected pattern byte.

The search has two phases. The first sweeps upward from delay 0 until all eight bytes pass at one delay, and that delay becomes the window start. The second keeps sweeping until a delay shows any failure, and that delay becomes the window end. After one further FIFO reset, the lane is programmed to the midpoint. A lane whose sweep would run past delay 31 is abandoned with an error. Lanes are trained one after another. When the last lane is finished, a one-cycle completion pulse is raised together with an overall fail flag. The pattern must already be in memory before training starts.

Top module: `dqs_trainer`

## Requirements
- R1: After reset every lane delay reads 0, and `busy`, `done`, `fifo_rst` and `rd_req_valid` are low. Each lane's sweep begins at delay 0. Lane l's delay is `dly_o[5*l+4:5*l]`.
- R2: Each training read follows a fixed sequence. `fifo_rst` is high for PAUSE cycles, then low for PAUSE cycles. Then `stat_clr` is high for exactly one cycle, and the request is raised in the next cycle. No request is raised while `fifo_rst` is high.
- R3: The read of pattern byte i (i = 0..7) for lane l uses address l + 4*i. The expected bytes, in order of i, are 8'hFE, 8'h11, 8'h33, 8'h55, 8'h77, 8'h99, 8'hBB, 8'hDD.
- R4: A response with `rd_rsp_masked` or `rd_rsp_dummy` set counts as a mismatch, whatever data it carries.
- R5: In the first phase, any mismatch raises the lane delay by exactly 1 and restarts the eight-byte scan. The first delay at which all eight bytes match is recorded as the window start.
- R6: In the second phase, all eight bytes are reread at each delay. When all of them match, the delay rises by 1. The first delay with any mismatch is the window end.
- R7: The final lane delay is start + ((end − start) >> 1). It is written after one extra FIFO reset pulse that is not followed by a read.
- R8: If a lane needs an increment while its delay is 31, in either phase, the lane ends with an error. Its delay is left at 31 and training moves to the next lane.
- R9: Lanes are trained in order from 0 to LANES−1. After the last lane, `done` is high for exactly one cycle. `fail` equals the OR of `lane_err`, and both hold until the next `start`.
- R10: At most one read is outstanding at a time. While `rd_req_valid` is high and `rd_req_ready` is low, the request and its address stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin training all lanes (accepted when idle) |
| busy | output | 1 | Training in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | At least one lane ended with an error |
| lane_err | output | LANES | Per-lane error result |
| dly_o | output | 5*LANES | Delay setting for every lane |
| fifo_rst | output | 1 | PHY read-FIFO reset |
| stat_clr | output | 1 | Clear sticky read-status flags |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_addr | output | AW | Byte address of the read |
| rd_rsp_valid | input | 1 | Read response valid |
| rd_rsp_data | input | 8 | Returned byte |
| rd_rsp_masked | input | 1 | Masked-data status flag |
| rd_rsp_dummy | input | 1 | Dummy-data status flag |

## Verification
Two decisions can fall on the same response cycle. One is the per-byte verdict: a masked or dummy flag, or a data mismatch. The other is the range limit, when the delay is already at 31 and an increment is due. The bench provokes this in two ways: a lane with no passing delay at all, and a lane whose window runs up to 31 so that the second phase passes at the top delay. In both cases it expects an error with the delay parked at 31 and the next lane still trained normally. Status flags are also injected at the very delay where a window would otherwise start or end. The bench then checks that the recorded start and end move, and that the centred delay moves with them.

// File: rtl/dqs_trainer.sv
module dqs_trainer #(
  parameter int LANES = 2,
  parameter int AW    = 12,
  parameter int PAUSE = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  output logic               busy,
  output logic               done,
  output logic               fail,
  output logic [LANES-1:0]   lane_err,
  output logic [5*LANES-1:0] dly_o,
  output logic               fifo_rst,
  output logic               stat_clr,
  output logic               rd_req_valid,
  input  logic               rd_req_ready,
  output logic [AW-1:0]      rd_addr,
  input  logic               rd_rsp_valid,
  input  logic [7:0]         rd_rsp_data,
  input  logic               rd_rsp_masked,
  input  logic               rd_rsp_dummy
);
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int PW = $clog2(PAUSE + 1);
  localparam logic [4:0] DMAX = 5'd31;

  typedef enum logic [3:0] {
    S_IDLE, S_RA, S_RB, S_CLR, S_REQ, S_WAIT, S_SET, S_NEXT
  } st_t;

  st_t            st;
  logic [LW-1:0]  lane;
  logic [2:0]     idx;
  logic           ph2, fin;
  logic [PW-1:0]  cnt;
  logic [4:0]     wstart;
  logic [4:0]     dly [LANES];
  logic [4:0]     cur;
  logic           hit;

  function automatic logic [7:0] pat(input logic [2:0] i);
    case (i)
      3'd0: pat = 8'hFE;
      3'd1: pat = 8'h11;
      3'd2: pat = 8'h33;
      3'd3: pat = 8'h55;
      3'd4: pat = 8'h77;
      3'd5: pat = 8'h99;
      3'd6: pat = 8'hBB;
      default: pat = 8'hDD;
    endcase
  endfunction

  assign cur = dly[lane];
  assign hit = !rd_rsp_masked && !rd_rsp_dummy && (rd_rsp_data == pat(idx));

  for (genvar g = 0; g < LANES; g++) begin : g_out
    assign dly_o[5*g +: 5] = dly[g];
  end

  assign busy         = (st != S_IDLE);
  assign fifo_rst     = (st == S_RA);
  assign stat_clr     = (st == S_CLR);
  assign rd_req_valid = (st == S_REQ);
  assign rd_addr      = AW'(lane) + AW'({idx, 2'b00});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      lane     <= '0;
      idx      <= '0;
      ph2      <= 1'b0;
      fin      <= 1'b0;
      cnt      <= '0;
      wstart   <= '0;
      lane_err <= '0;
      done     <= 1'b0;
      fail     <= 1'b0;
      for (int k = 0; k < LANES; k++) dly[k] <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          lane     <= '0;
          dly[0]   <= '0;
          idx      <= '0;
          ph2      <= 1'b0;
          fin      <= 1'b0;
          cnt      <= '0;
          lane_err <= '0;
          fail     <= 1'b0;
          st       <= S_RA;
        end
        S_RA: begin
          if (cnt == PW'(PAUSE - 1)) begin
            cnt <= '0;
            st  <= S_RB;
          end else cnt <= cnt + 1'b1;
        end
        S_RB: begin
          if (cnt == PW'(PAUSE - 1)) begin
            cnt <= '0;
            st  <= fin ? S_SET : S_CLR;
          end else cnt <= cnt + 1'b1;
        end
        S_CLR: st <= S_REQ;
        S_REQ: if (rd_req_ready) st <= S_WAIT;
        S_WAIT: if (rd_rsp_valid) begin
          if (!ph2) begin
            if (!hit) begin
              idx <= '0;
              if (cur == DMAX) begin
                lane_err[lane] <= 1'b1;
                st <= S_NEXT;
              end else begin
                dly[lane] <= cur + 5'd1;
                st <= S_RA;
              end
            end else if (idx == 3'd7) begin
              wstart <= cur;
              ph2    <= 1'b1;
              idx    <= '0;
              st     <= S_RA;
            end else begin
              idx <= idx + 3'd1;
              st  <= S_RA;
            end
          end else begin
            if (!hit) begin
              fin <= 1'b1;
              st  <= S_RA;
            end else if (idx == 3'd7) begin
              idx <= '0;
              if (cur == DMAX) begin
                lane_err[lane] <= 1'b1;
                st <= S_NEXT;
              end else begin
                dly[lane] <= cur + 5'd1;
                st <= S_RA;
              end
            end else begin
              idx <= idx + 3'd1;
              st  <= S_RA;
            end
          end
        end
        S_SET: begin
          dly[lane] <= wstart + ((cur - wstart) >> 1);
          st <= S_NEXT;
        end
        S_NEXT: begin
          if (lane == LW'(LANES - 1)) begin
            done <= 1'b1;
            fail <= |lane_err;
            st   <= S_IDLE;
          end else begin
            lane                <= lane + LW'(1);
            dly[lane + LW'(1)]  <= '0;
            idx                 <= '0;
            ph2                 <= 1'b0;
            fin                 <= 1'b0;
            st                  <= S_RA;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dqs_trainer_chk.sv
module dqs_trainer_chk #(
  parameter int LANES = 2,
  parameter int AW    = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             fail,
  input logic [LANES-1:0] lane_err,
  input logic [4:0]       dly0,
  input logic             fifo_rst,
  input logic             stat_clr,
  input logic             rd_req_valid,
  input logic             rd_req_ready,
  input logic [AW-1:0]    rd_addr,
  input logic             rd_rsp_valid
);
  logic pend;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else if (rd_req_valid && rd_req_ready) pend <= 1'b1;
    else if (rd_rsp_valid) pend <= 1'b0;
  end

  assert_no_req_in_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> !fifo_rst);
  assert_clr_before_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_req_valid) |-> $past(stat_clr));
  assert_addr_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> (32'(rd_addr[1:0]) < LANES && 32'(rd_addr >> 2) < 8));
  assert_step_by_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dly0 > $past(dly0)) |-> dly0 == $past(dly0) + 5'd1);
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_fail_or_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fail == |lane_err));
  assert_one_outstanding_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> !pend);
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_addr)));
endmodule

bind dqs_trainer dqs_trainer_chk #(.LANES(LANES), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .fail(fail),
  .lane_err(lane_err), .dly0(dly_o[4:0]), .fifo_rst(fifo_rst),
  .stat_clr(stat_clr), .rd_req_valid(rd_req_valid),
  .rd_req_ready(rd_req_ready), .rd_addr(rd_addr), .rd_rsp_valid(rd_rsp_valid)
);

// File: tb/dqs_trainer_tb.sv
module dqs_trainer_tb;
  localparam int LANES = 2;
  localparam int AW    = 12;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic busy, done, fail, fifo_rst, stat_clr, rd_req_valid, rd_req_ready;
  logic [LANES-1:0] lane_err;
  logic [5*LANES-1:0] dly_o;
  logic [AW-1:0] rd_addr;
  logic rd_rsp_valid = 1'b0, rd_rsp_masked = 1'b0, rd_rsp_dummy = 1'b0;
  logic [7:0] rd_rsp_data = 8'h00;

  int checks = 0, errors = 0;
  int lo [LANES], hi [LANES], mask_at [LANES], dummy_at [LANES];
  int viol = 0, reads = 0, rst_rises = 0;
  logic saw_rst = 1'b0, saw_clr = 1'b0, prev_rst = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  always #4 clk = ~clk;

  dqs_trainer #(.LANES(LANES), .AW(AW), .PAUSE(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .fail(fail), .lane_err(lane_err), .dly_o(dly_o), .fifo_rst(fifo_rst),
    .stat_clr(stat_clr), .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready), .rd_addr(rd_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .rd_rsp_masked(rd_rsp_masked), .rd_rsp_dummy(rd_rsp_dummy)
  );

  function automatic logic [7:0] exp_byte(input int i);
    case (i)
      0: return 8'hFE; 1: return 8'h11; 2: return 8'h33; 3: return 8'h55;
      4: return 8'h77; 5: return 8'h99; 6: return 8'hBB; default: return 8'hDD;
    endcase
  endfunction

  assign rd_req_ready = lfsr[0] | lfsr[3];

  // Memory model: one-cycle response latency, protocol bookkeeping
  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    prev_rst <= fifo_rst;
    if (fifo_rst && !prev_rst) begin rst_rises <= rst_rises + 1; saw_rst <= 1'b1; end
    if (stat_clr) saw_clr <= 1'b1;
    rd_rsp_valid <= 1'b0;
    if (rd_req_valid && rd_req_ready) begin
      automatic int ln = int'(rd_addr[1:0]);
      automatic int i  = int'(rd_addr >> 2);
      automatic int d;
      if (!saw_rst || !saw_clr || ln >= LANES || i > 7) viol <= viol + 1;
      if (ln >= LANES) ln = 0;
      d = int'(dly_o[5*ln +: 5]);
      reads <= reads + 1;
      saw_rst <= 1'b0;
      saw_clr <= 1'b0;
      rd_rsp_valid  <= 1'b1;
      rd_rsp_data   <= (d >= lo[ln] && d <= hi[ln]) ? exp_byte(i) : (exp_byte(i) ^ 8'h40);
      rd_rsp_masked <= (d == mask_at[ln]);
      rd_rsp_dummy  <= (d == dummy_at[ln]) && (i == 5);
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run(input int exp_reads_lanes_ok, input string req,
                     input logic [LANES-1:0] exp_err, input int e0, input int e1);
    int t = 0;
    int r0;
    r0 = rst_rises - reads;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done && t < 40000) begin @(negedge clk); t++; end
    check(done === 1'b1, req, "done seen", int'(done), 1);
    check(fail === |exp_err, "R9", "fail flag", int'(fail), int'(|exp_err));
    check(lane_err === exp_err, "R8", "lane_err", int'(lane_err), int'(exp_err));
    check(int'(dly_o[4:0]) == e0, req, "lane0 delay", int'(dly_o[4:0]), e0);
    check(int'(dly_o[9:5]) == e1, req, "lane1 delay", int'(dly_o[9:5]), e1);
    check(viol == 0, "R2", "read protocol violations", viol, 0);
    check((rst_rises - reads) - r0 == exp_reads_lanes_ok, "R7", "extra FIFO resets",
          (rst_rises - reads) - r0, exp_reads_lanes_ok);
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, "R9", "done single pulse", int'(done), 0);
  endtask

  task automatic set_lane(input int l, input int a, input int b, input int m, input int du);
    lo[l] = a; hi[l] = b; mask_at[l] = m; dummy_at[l] = du;
  endtask

  task automatic t_reset();
    check(dly_o === '0, "R1", "delays after reset", int'(dly_o), 0);
    check(busy === 1'b0 && done === 1'b0, "R1", "busy/done after reset", int'(busy), 0);
    check(fifo_rst === 1'b0 && rd_req_valid === 1'b0, "R1", "fifo_rst/req after reset", int'(fifo_rst), 0);
  endtask

  task automatic t_basic();  // R3 R5 R6 R7: lane0 [5,12] -> 9, lane1 [0,3] -> 2
    set_lane(0, 5, 12, -1, -1); set_lane(1, 0, 3, -1, -1);
    run(2, "R5", 2'b00, 9, 2);
  endtask

  task automatic t_no_window();  // R8: lane0 never passes, lane1 [2,9] -> 6
    set_lane(0, 1, 0, -1, -1); set_lane(1, 2, 9, -1, -1);
    run(1, "R8", 2'b01, 31, 6);
  endtask

  task automatic t_top_edge();  // R8: lane1 window reaches 31; lane0 [0,0] -> 0
    set_lane(0, 0, 0, -1, -1); set_lane(1, 20, 31, -1, -1);
    run(1, "R6", 2'b10, 0, 31);
  endtask

  task automatic t_flags();  // R4: masked at 4 -> start 5, dummy at 8 -> end 8 -> 6; lane1 [10,25] -> 18
    set_lane(0, 4, 10, 4, 8); set_lane(1, 10, 25, -1, -1);
    run(2, "R4", 2'b00, 6, 18);
  endtask

  initial begin
    for (int l = 0; l < LANES; l++) set_lane(l, 0, 31, -1, -1);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_basic();
    t_no_window();
    t_top_edge();
    t_flags();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule